// File: doc/BRIEF.md
# Latched Sixteen-Bit Interval Timer Pair

This block holds two independent 16-bit down-counters that software programs through a small byte-wide register window. The first timer has a full 16-bit reload latch. In its repeating mode it reloads from that latch and produces an expiry pulse once per period. The second timer is a one-shot. Its counter is loaded from a byte written to its upper address together with a low byte that was stored earlier. Both counters move only on cycles where the `tick` clock-enable is high, so one fast clock can drive a slow timebase.

The block keeps no interrupt flags. It gives the neighbouring flag/enable logic a one-cycle "set" pulse when a timer expires and a "clear" strobe when a register access should acknowledge that timer. Reads are combinational from the current state. The byte offsets are fixed because the register decoder of the surrounding adapter depends on them.

Top module: `timer_pair`

## Requirements
- R1: After synchronous reset the first timer's latch and counter read 0xFFFF, the second timer's counter reads 0xFFFF, its stored low byte is 0x00, and neither set output is high.
- R2: A write to offset 4 or offset 6 replaces only the low byte of the first timer's latch and leaves its counter alone.
- R3: A write to offset 5 places the byte in the latch's high half and loads the counter with the whole new latch in the same clock. It asserts `t1_clr` during the write cycle and arms the single expiry report.
- R4: A write to offset 7 replaces the latch's high byte and asserts `t1_clr` without changing the counter.
- R5: The read map is as follows: 4 and 5 give the first counter's low and high byte, 6 and 7 give the latch bytes, 8 and 9 give the second counter's low and high byte, and every other offset gives 0x00. A read of offset 4 asserts `t1_clr`.
- R6: The first counter decrements by one on each cycle with `tick` high and holds its value on every other cycle.
- R7: With `t1_mode` equal to 2'b01 (repeating), the tick after the first counter wrapped from 0x0000 to 0xFFFF loads the latch value, so a steady loop lasts latch+2 ticks.
- R8: `t1_set` is high for exactly the cycle after a tick that moves the first counter onto 0x0000. In repeating mode this happens on every such tick. In any other mode it happens only on the first such tick after a write to offset 5.
- R9: Outside repeating mode the first counter continues downward past 0xFFFF with no reload.
- R10: A write to offset 8 stores the second timer's low byte. A write to offset 9 loads its counter with {written byte, stored low byte}.
- R11: The second counter decrements on each tick, wraps from 0x0000 to 0xFFFF, and pulses `t2_set` in the cycle after the first tick that reaches 0x0000 following a write to offset 9.
- R12: A read of offset 8 asserts `t2_clr` during the read cycle.
- R13: When a counter-loading write (offset 5 or 9) falls on a tick cycle, the load wins and that tick does not decrement the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one count per high cycle |
| t1_mode | input | 2 | First-timer mode bits, 2'b01 selects repeating |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clear side effects) |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| t1_set | output | 1 | First timer expiry pulse |
| t1_clr | output | 1 | First timer acknowledge strobe |
| t2_set | output | 1 | Second timer expiry pulse |
| t2_clr | output | 1 | Second timer acknowledge strobe |

## Verification
The hardest situations to reach from the ports are expiries. A 16-bit counter loaded with a random value almost never gets to zero inside a short run. The repeating reload also needs the wrap to 0xFFFF before it happens. For that reason the random stimulus writes small low bytes and mostly-zero high bytes, so that loads land in a range of a few dozen ticks. It also toggles the mode while counts are running, which reaches the reload, re-arm and "already reported" paths many times. Directed sequences then cover the load-on-tick collision and the reset state of the second timer's stored low byte.

// File: rtl/timer_pair_pkg.sv
package timer_pair_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 4;

    typedef logic [CNT_W-1:0]  count_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Byte offsets decoded by the neighbouring adapter logic
    localparam logic [ADDR_W-1:0] OFF_T1_CLO = 4'd4;
    localparam logic [ADDR_W-1:0] OFF_T1_CHI = 4'd5;
    localparam logic [ADDR_W-1:0] OFF_T1_LLO = 4'd6;
    localparam logic [ADDR_W-1:0] OFF_T1_LHI = 4'd7;
    localparam logic [ADDR_W-1:0] OFF_T2_CLO = 4'd8;
    localparam logic [ADDR_W-1:0] OFF_T2_CHI = 4'd9;

    localparam logic [1:0] MODE_REPEAT = 2'b01;

    typedef struct packed {
        logic wr_lo;     // offset 4 or 6
        logic wr_load;   // offset 5
        logic wr_hi;     // offset 7
    } t1_ctl_t;

    typedef struct packed {
        logic wr_lo;     // offset 8
        logic wr_load;   // offset 9
    } t2_ctl_t;

    function automatic count_t count_down(input count_t c);
        return c - count_t'(1);
    endfunction

    function automatic byte_t pick_byte(input count_t c, input logic hi);
        return hi ? c[CNT_W-1:BYTE_W] : c[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/timer_pair_t1.sv
module timer_pair_t1
    import timer_pair_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     repeat_en,
    input  t1_ctl_t  ctl,
    input  byte_t    wdata,
    output count_t   cnt,
    output count_t   latch,
    output logic     set_pulse
);

    count_t latch_q, latch_d;
    count_t cnt_q, cnt_d;
    logic   under_q, under_d;
    logic   armed_q, armed_d;
    logic   set_q, set_d;
    logic   reload;

    assign reload = repeat_en && under_q;

    always_comb begin
        latch_d = latch_q;
        if (ctl.wr_lo)
            latch_d[BYTE_W-1:0] = wdata;
        if (ctl.wr_load || ctl.wr_hi)
            latch_d[CNT_W-1:BYTE_W] = wdata;

        cnt_d   = cnt_q;
        under_d = under_q;
        armed_d = armed_q;
        set_d   = 1'b0;
        if (ctl.wr_load) begin
            cnt_d   = {wdata, latch_q[BYTE_W-1:0]};
            under_d = 1'b0;
            armed_d = 1'b1;
        end else if (tick) begin
            cnt_d   = reload ? latch_q : count_down(cnt_q);
            under_d = !reload && (cnt_q == '0);
            if ((cnt_d == '0) && (repeat_en || armed_q)) begin
                set_d   = 1'b1;
                armed_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '1;
            cnt_q   <= '1;
            under_q <= 1'b0;
            armed_q <= 1'b0;
            set_q   <= 1'b0;
        end else begin
            latch_q <= latch_d;
            cnt_q   <= cnt_d;
            under_q <= under_d;
            armed_q <= armed_d;
            set_q   <= set_d;
        end
    end

    assign cnt       = cnt_q;
    assign latch     = latch_q;
    assign set_pulse = set_q;

    // R3
    t1_load_copies_latch_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.wr_load |=> cnt_q == latch_q);

    // R6
    t1_idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ctl.wr_load) |=> $stable(cnt_q));

    // R7
    t1_repeat_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctl.wr_load && repeat_en && under_q) |=> cnt_q == $past(latch_q));

    // R9
    t1_oneshot_counts_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctl.wr_load && !repeat_en) |=> cnt_q == $past(cnt_q) - count_t'(1));

    // R8
    t1_set_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        set_q |-> cnt_q == '0);

endmodule

// File: rtl/timer_pair_t2.sv
module timer_pair_t2
    import timer_pair_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  t2_ctl_t  ctl,
    input  byte_t    wdata,
    output count_t   cnt,
    output logic     set_pulse
);

    byte_t  lo_q, lo_d;
    count_t cnt_q, cnt_d;
    logic   armed_q, armed_d;
    logic   set_q, set_d;

    always_comb begin
        lo_d    = ctl.wr_lo ? wdata : lo_q;
        cnt_d   = cnt_q;
        armed_d = armed_q;
        set_d   = 1'b0;
        if (ctl.wr_load) begin
            cnt_d   = {wdata, lo_q};
            armed_d = 1'b1;
        end else if (tick) begin
            cnt_d = count_down(cnt_q);
            if ((cnt_d == '0) && armed_q) begin
                set_d   = 1'b1;
                armed_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= '0;
            cnt_q   <= '1;
            armed_q <= 1'b0;
            set_q   <= 1'b0;
        end else begin
            lo_q    <= lo_d;
            cnt_q   <= cnt_d;
            armed_q <= armed_d;
            set_q   <= set_d;
        end
    end

    assign cnt       = cnt_q;
    assign set_pulse = set_q;

    // R10
    t2_load_low_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.wr_load |=> cnt_q[BYTE_W-1:0] == $past(lo_q));

    // R11
    t2_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !ctl.wr_load && cnt_q == '0) |=> cnt_q == '1);

    // R11
    t2_set_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        set_q |-> cnt_q == '0);

    // R13
    t2_load_beats_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && ctl.wr_load) |=> cnt_q[CNT_W-1:BYTE_W] == $past(wdata));

endmodule

// File: rtl/timer_pair.sv
module timer_pair
    import timer_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] t1_mode,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       t1_set,
    output logic       t1_clr,
    output logic       t2_set,
    output logic       t2_clr
);

    t1_ctl_t t1_ctl;
    t2_ctl_t t2_ctl;
    count_t  t1_cnt, t1_latch, t2_cnt;

    always_comb begin
        t1_ctl.wr_lo   = bus_wr && (bus_addr == OFF_T1_CLO || bus_addr == OFF_T1_LLO);
        t1_ctl.wr_load = bus_wr && (bus_addr == OFF_T1_CHI);
        t1_ctl.wr_hi   = bus_wr && (bus_addr == OFF_T1_LHI);
        t2_ctl.wr_lo   = bus_wr && (bus_addr == OFF_T2_CLO);
        t2_ctl.wr_load = bus_wr && (bus_addr == OFF_T2_CHI);
    end

    timer_pair_t1 u_t1 (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .repeat_en (t1_mode == MODE_REPEAT),
        .ctl       (t1_ctl),
        .wdata     (bus_wdata),
        .cnt       (t1_cnt),
        .latch     (t1_latch),
        .set_pulse (t1_set)
    );

    timer_pair_t2 u_t2 (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .ctl       (t2_ctl),
        .wdata     (bus_wdata),
        .cnt       (t2_cnt),
        .set_pulse (t2_set)
    );

    always_comb begin
        case (bus_addr)
            OFF_T1_CLO: bus_rdata = pick_byte(t1_cnt, 1'b0);
            OFF_T1_CHI: bus_rdata = pick_byte(t1_cnt, 1'b1);
            OFF_T1_LLO: bus_rdata = pick_byte(t1_latch, 1'b0);
            OFF_T1_LHI: bus_rdata = pick_byte(t1_latch, 1'b1);
            OFF_T2_CLO: bus_rdata = pick_byte(t2_cnt, 1'b0);
            OFF_T2_CHI: bus_rdata = pick_byte(t2_cnt, 1'b1);
            default:    bus_rdata = '0;
        endcase
    end

    assign t1_clr = t1_ctl.wr_load || t1_ctl.wr_hi || (bus_rd && bus_addr == OFF_T1_CLO);
    assign t2_clr = bus_rd && (bus_addr == OFF_T2_CLO);

    // R2
    t1_lowbyte_write_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
        (t1_ctl.wr_lo && !tick) |=> $stable(t1_cnt));

    // R4
    t1_hi_write_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
        (t1_ctl.wr_hi && !tick) |=> $stable(t1_cnt));

    // R8
    t1_set_single_chk: assert property (@(posedge clk) disable iff (rst)
        (t1_set && t1_mode != MODE_REPEAT && $stable(t1_mode)) |=> !t1_set);

endmodule

// File: tb/timer_pair_tb.sv
module timer_pair_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic [1:0] t1_mode;
    logic       bus_wr, bus_rd;
    logic [3:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       t1_set, t1_clr, t2_set, t2_clr;

    always #5 clk = ~clk;

    timer_pair u_dut (
        .clk(clk), .rst(rst), .tick(tick), .t1_mode(t1_mode),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .t1_set(t1_set), .t1_clr(t1_clr), .t2_set(t2_set), .t2_clr(t2_clr)
    );

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 0;
    logic [1:0] g_mode = 2'b00;

    // reference state
    logic [15:0] m1c, m1l, m2c;
    logic [7:0]  m2l;
    bit          m1u, m1a, m2a, ms1, ms2;

    task automatic model_reset();
        m1c = 16'hFFFF; m1l = 16'hFFFF; m2c = 16'hFFFF; m2l = 8'h00;
        m1u = 0; m1a = 0; m2a = 0; ms1 = 0; ms2 = 0;
    endtask

    function automatic logic [7:0] exp_rdata(input logic [3:0] a);
        case (a)
            4'd4: return m1c[7:0];
            4'd5: return m1c[15:8];
            4'd6: return m1l[7:0];
            4'd7: return m1l[15:8];
            4'd8: return m2c[7:0];
            4'd9: return m2c[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic cmp(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_update(input logic wr, input logic [3:0] a, input logic [7:0] d, input logic tk);
        logic [15:0] nl, n;
        bit cont, s1, s2;
        cont = (g_mode == 2'b01);
        nl = m1l;
        if (wr && (a == 4'd4 || a == 4'd6)) nl[7:0] = d;
        if (wr && (a == 4'd5 || a == 4'd7)) nl[15:8] = d;
        s1 = 0;
        if (wr && a == 4'd5) begin
            m1c = {d, m1l[7:0]}; m1u = 0; m1a = 1;
        end else if (tk) begin
            if (cont && m1u) begin n = m1l; m1u = 0; end
            else begin n = m1c - 16'd1; m1u = (m1c == 16'd0); end
            if (n == 16'd0 && (cont || m1a)) begin s1 = 1; m1a = 0; end
            m1c = n;
        end
        m1l = nl;
        s2 = 0;
        if (wr && a == 4'd9) begin
            m2c = {d, m2l}; m2a = 1;
        end else if (tk) begin
            n = m2c - 16'd1;
            if (n == 16'd0 && m2a) begin s2 = 1; m2a = 0; end
            m2c = n;
        end
        if (wr && a == 4'd8) m2l = d;
        ms1 = s1; ms2 = s2;
    endtask

    task automatic step(input logic wr, input logic rd, input logic [3:0] a,
                        input logic [7:0] d, input logic tk, input string tag);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tick = tk; t1_mode = g_mode;
        #1;
        cmp(tag, "rdata", {8'h00, bus_rdata}, {8'h00, exp_rdata(a)});
        cmp(tag, "t1_set", {15'd0, t1_set}, {15'd0, ms1});
        cmp(tag, "t2_set", {15'd0, t2_set}, {15'd0, ms2});
        cmp(tag, "t1_clr", {15'd0, t1_clr},
            {15'd0, (wr && (a == 4'd5 || a == 4'd7)) || (rd && a == 4'd4)});
        cmp(tag, "t2_clr", {15'd0, t2_clr}, {15'd0, rd && a == 4'd8});
        model_update(wr, a, d, tk);
    endtask

    task automatic rd_reg(input logic [3:0] a, input string tag);
        step(1'b0, 1'b1, a, 8'h00, 1'b0, tag);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d, input string tag);
        step(1'b1, 1'b0, a, d, 1'b0, tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int r;
        rst = 1'b1; tick = 1'b0; t1_mode = 2'b00;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd_reg(4'd4, "R1"); rd_reg(4'd5, "R1"); rd_reg(4'd6, "R1");
        rd_reg(4'd7, "R1"); rd_reg(4'd9, "R1");
        wr_reg(4'd9, 8'h12, "R1");
        rd_reg(4'd8, "R1");
        rd_reg(4'd9, "R10");

        // R2 low-byte writes touch only the latch
        wr_reg(4'd4, 8'h03, "R2");
        rd_reg(4'd4, "R2"); rd_reg(4'd6, "R2");
        wr_reg(4'd6, 8'h03, "R2");
        rd_reg(4'd5, "R2");

        // R3 load through offset 5, then one-shot expiry
        wr_reg(4'd5, 8'h00, "R3");
        rd_reg(4'd4, "R3");
        ticks(4, "R8");
        ticks(5, "R9");
        rd_reg(4'd5, "R9"); rd_reg(4'd4, "R6");

        // R4 high latch write without reload
        wr_reg(4'd7, 8'h01, "R4");
        rd_reg(4'd5, "R4"); rd_reg(4'd7, "R4");
        rd_reg(4'd11, "R5");

        // R7 repeating mode, latch = 2, period 4
        g_mode = 2'b01;
        wr_reg(4'd6, 8'h02, "R7");
        wr_reg(4'd5, 8'h00, "R7");
        ticks(12, "R7");
        rd_reg(4'd4, "R7");

        // R13 load on a tick cycle
        step(1'b1, 1'b0, 4'd5, 8'h00, 1'b1, "R13");
        rd_reg(4'd4, "R13");
        ticks(3, "R13");

        // R10 / R11 / R12 second timer
        wr_reg(4'd8, 8'h02, "R10");
        wr_reg(4'd9, 8'h00, "R10");
        rd_reg(4'd8, "R10");
        ticks(4, "R11");
        rd_reg(4'd9, "R11");
        rd_reg(4'd8, "R12");
        step(1'b1, 1'b0, 4'd9, 8'h00, 1'b1, "R13");
        ticks(3, "R11");

        // constrained random phase
        r = $urandom(32'h5eed);
        for (int i = 0; i < 4000; i++) begin
            int p;
            logic [3:0] a;
            logic [7:0] d;
            logic tk;
            p  = $urandom % 100;
            tk = ($urandom % 3) != 0;
            if (($urandom % 50) == 0) g_mode = 2'($urandom % 4);
            if (p < 10) begin
                a = 4'(4 + ($urandom % 6));
                if (a == 4'd5 || a == 4'd7 || a == 4'd9)
                    d = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
                else
                    d = 8'($urandom % 24);
                step(1'b1, 1'b0, a, d, tk, "R6");
            end else if (p < 20) begin
                a = 4'($urandom % 16);
                step(1'b0, 1'b1, a, 8'h00, tk, "R5");
            end else begin
                step(1'b0, 1'b0, 4'($urandom % 16), 8'h00, tk, "R8");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule